// File: doc/BRIEF.md
# Train command sequencer

This block builds the per-train command stream that goes out to the front-end electronics. It runs on an uninterrupted fast clock that is phase-locked to the bunch clock, with twenty fast cycles to one bunch period. For each accepted trigger it waits a programmable number of cycles and then shifts a framed sequence out on a single command line, one bit per cycle. The frame is a start marker, the 32-bit train number, the 8-bit pattern number and a stop marker. While the line is idle it is held low.

The trigger, the train number and the pattern number come from one of three sources, picked by a select input. The first is a timing receiver. The second is a secondary external interface. The third is an internal standalone generator that fires every N bunch periods and counts its own train numbers. A crate busy signal drops a whole train at the moment its start would go out. A trigger that arrives while a frame is still pending or being sent is dropped and counted. The pattern number also indexes a writable lookup table, and the table gives the full bunch pattern for the train being sent. The bunch veto line passes through alongside the command stream with a fixed one-cycle latency.

Top module: `train_cmd_seq`

## Requirements
- R1: A frame is 46 bits, one bit per cycle, in this order: start marker 3'b110, then the 32-bit train number MSB first, then the 8-bit pattern number MSB first, then stop marker 3'b011. `cmd_o` is 0 whenever no frame is being sent.
- R2: If a trigger is presented in cycle n with `delay_i` = D, the first start-marker bit is on `cmd_o` in cycle n+2+D.
- R3: `src_sel_i` picks the trigger, train number and pattern number source: 0 timing receiver, 1 external interface, 2 standalone generator, 3 none. Inputs of sources that are not selected have no effect on `cmd_o`.
- R4: With source 2, a trigger fires on every Nth rising edge of `bunch_clk_i`, where N = `sa_period_i` and 0 is treated as 1. The train numbers start at 0 after reset and rise by one per trigger. The pattern number is `sa_pattern_id_i`.
- R5: If `busy_i` is high in the cycle in which the start marker would be issued, the whole train is dropped and no bit of it appears.
- R6: When a frame's start is issued, `bunch_pattern_o` takes the lookup-table entry addressed by that frame's pattern number. Entries are written through `lut_we_i`/`lut_addr_i`/`lut_data_i`.
- R7: `veto_o` equals `veto_i` delayed by one cycle.
- R8: A trigger that arrives while a frame is pending (in its delay) or being sent is dropped and adds one to `overrun_cnt_o`, which saturates.
- R9: After reset, `cmd_o`, `veto_o`, `overrun_cnt_o` and `bunch_pattern_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, phase-locked to the bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | Source select (0 receiver, 1 external, 2 standalone, 3 none) |
| rx_trig_i | input | 1 | Receiver trigger pulse |
| rx_train_id_i | input | 32 | Receiver train number |
| rx_pattern_id_i | input | 8 | Receiver pattern number |
| ext_trig_i | input | 1 | External-interface trigger pulse |
| ext_train_id_i | input | 32 | External-interface train number |
| ext_pattern_id_i | input | 8 | External-interface pattern number |
| bunch_clk_i | input | 1 | Bunch clock, sampled in the fast domain |
| sa_period_i | input | 8 | Standalone trigger period in bunch periods |
| sa_pattern_id_i | input | 8 | Standalone pattern number |
| delay_i | input | 8 | Trigger-to-start delay in cycles |
| busy_i | input | 1 | Crate busy, drops the next train |
| veto_i | input | 1 | Bunch veto in |
| lut_we_i | input | 1 | Pattern table write enable |
| lut_addr_i | input | 8 | Pattern table write address |
| lut_data_i | input | 16 | Pattern table write data |
| cmd_o | output | 1 | Serial command line |
| veto_o | output | 1 | Bunch veto out |
| bunch_pattern_o | output | 16 | Bunch pattern of the current train |
| overrun_cnt_o | output | 8 | Count of dropped overlapping triggers |

## Verification
On every cycle the assertions check four things. A frame only begins from the delay state and never while busy is high. The bit counter stays inside the frame length. An overlapping trigger always leaves a non-zero overrun count. Standalone triggers are single-cycle pulses. Only the bench scenarios can show the rest: the exact bit content and order of a frame, the trigger-to-start latency for each delay, the source selection with conflicting inputs on the other source, the standalone spacing and numbering, and the pattern table value paired with each train.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    SRC_RX  = 2'd0,
    SRC_EXT = 2'd1,
    SRC_SA  = 2'd2,
    SRC_OFF = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_SEND = 2'd2
  } seq_e;

  localparam int          MARK_W     = 3;
  localparam logic [2:0]  MARK_START = 3'b110;
  localparam logic [2:0]  MARK_STOP  = 3'b011;
endpackage

// File: rtl/tcs_rst_sync.sv
module tcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tcs_sa_gen.sv
module tcs_sa_gen #(
  parameter int ID_W  = 32,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             bunch_clk_i,
  input  logic [PER_W-1:0] period_i,
  output logic             trig_o,
  output logic [ID_W-1:0]  id_o
);
  logic             bclk_q;
  logic [PER_W-1:0] pcnt_q, pcnt_d;
  logic             trig_q, trig_d;
  logic [ID_W-1:0]  cur_q, cur_d;
  logic [ID_W-1:0]  nxt_q, nxt_d;
  logic             tick, fire;
  logic [PER_W-1:0] per_m1;

  always_comb begin
    tick   = bunch_clk_i & ~bclk_q;
    per_m1 = (period_i == '0) ? '0 : period_i - 1'b1;
    fire   = en_i & tick & (pcnt_q >= per_m1);
    pcnt_d = pcnt_q;
    if (!en_i)      pcnt_d = '0;
    else if (fire)  pcnt_d = '0;
    else if (tick)  pcnt_d = pcnt_q + 1'b1;
    trig_d = fire;
    cur_d  = fire ? nxt_q : cur_q;
    nxt_d  = fire ? nxt_q + 1'b1 : nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      pcnt_q <= '0;
      trig_q <= 1'b0;
      cur_q  <= '0;
      nxt_q  <= '0;
    end else begin
      bclk_q <= bunch_clk_i;
      pcnt_q <= pcnt_d;
      trig_q <= trig_d;
      if (fire) begin
        cur_q <= cur_d;
        nxt_q <= nxt_d;
      end
    end
  end

  assign trig_o = trig_q;
  assign id_o   = cur_q;

  // R4: standalone triggers are one-cycle pulses
  a_r4_sa_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);
endmodule

// File: rtl/tcs_src_sel.sv
module tcs_src_sel #(
  parameter int ID_W  = 32,
  parameter int PID_W = 8
) (
  input  logic [1:0]       sel_i,
  input  logic             rx_trig_i,
  input  logic [ID_W-1:0]  rx_id_i,
  input  logic [PID_W-1:0] rx_pid_i,
  input  logic             ext_trig_i,
  input  logic [ID_W-1:0]  ext_id_i,
  input  logic [PID_W-1:0] ext_pid_i,
  input  logic             sa_trig_i,
  input  logic [ID_W-1:0]  sa_id_i,
  input  logic [PID_W-1:0] sa_pid_i,
  output logic             trig_o,
  output logic [ID_W-1:0]  id_o,
  output logic [PID_W-1:0] pid_o
);
  import tcs_pkg::*;
  src_e sel;

  always_comb begin
    sel    = src_e'(sel_i);
    trig_o = 1'b0;
    id_o   = '0;
    pid_o  = '0;
    case (sel)
      SRC_RX: begin
        trig_o = rx_trig_i;
        id_o   = rx_id_i;
        pid_o  = rx_pid_i;
      end
      SRC_EXT: begin
        trig_o = ext_trig_i;
        id_o   = ext_id_i;
        pid_o  = ext_pid_i;
      end
      SRC_SA: begin
        trig_o = sa_trig_i;
        id_o   = sa_id_i;
        pid_o  = sa_pid_i;
      end
      default: begin
        trig_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tcs_pattern_lut.sv
module tcs_pattern_lut #(
  parameter int PID_W = 8,
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [PID_W-1:0] waddr_i,
  input  logic [PAT_W-1:0] wdata_i,
  input  logic [PID_W-1:0] raddr_i,
  output logic [PAT_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << PID_W;

  logic [PAT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tcs_frame_seq.sv
module tcs_frame_seq #(
  parameter int ID_W  = 32,
  parameter int PID_W = 8,
  parameter int PAT_W = 16,
  parameter int DLY_W = 8,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             busy_i,
  input  logic [PAT_W-1:0] lut_pat_i,
  output logic [PID_W-1:0] lut_addr_o,
  output logic             cmd_o,
  output logic [PAT_W-1:0] pattern_o,
  output logic [OVR_W-1:0] ovr_cnt_o
);
  import tcs_pkg::*;

  localparam int FRAME_LEN = 2 * MARK_W + ID_W + PID_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  seq_e                 state_q, state_d;
  logic [DLY_W-1:0]     dcnt_q, dcnt_d;
  logic [ID_W-1:0]      id_q;
  logic [PID_W-1:0]     pid_q;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]     bcnt_q, bcnt_d;
  logic [PAT_W-1:0]     pat_q;
  logic [OVR_W-1:0]     ovr_q, ovr_d;
  logic                 cap_en, load_en, overrun;

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    sh_d    = sh_q;
    bcnt_d  = bcnt_q;
    cap_en  = 1'b0;
    load_en = 1'b0;
    overrun = trig_i && (state_q != SEQ_IDLE);
    case (state_q)
      SEQ_IDLE: begin
        if (trig_i) begin
          cap_en  = 1'b1;
          dcnt_d  = delay_i;
          state_d = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (dcnt_q == '0) begin
          if (busy_i) begin
            state_d = SEQ_IDLE;
          end else begin
            load_en = 1'b1;
            sh_d    = {MARK_START, id_q, pid_q, MARK_STOP};
            bcnt_d  = '0;
            state_d = SEQ_SEND;
          end
        end else begin
          dcnt_d = dcnt_q - 1'b1;
        end
      end
      SEQ_SEND: begin
        sh_d = {sh_q[FRAME_LEN-2:0], 1'b0};
        if (bcnt_q == LAST_BIT) state_d = SEQ_IDLE;
        else                    bcnt_d  = bcnt_q + 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
    ovr_d = ovr_q;
    if (overrun && (ovr_q != {OVR_W{1'b1}})) ovr_d = ovr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dcnt_q  <= '0;
      id_q    <= '0;
      pid_q   <= '0;
      sh_q    <= '0;
      bcnt_q  <= '0;
      pat_q   <= '0;
      ovr_q   <= '0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      sh_q    <= sh_d;
      bcnt_q  <= bcnt_d;
      ovr_q   <= ovr_d;
      if (cap_en) begin
        id_q  <= id_i;
        pid_q <= pid_i;
      end
      if (load_en) pat_q <= lut_pat_i;
    end
  end

  assign lut_addr_o = pid_q;
  assign cmd_o      = (state_q == SEQ_SEND) & sh_q[FRAME_LEN-1];
  assign pattern_o  = pat_q;
  assign ovr_cnt_o  = ovr_q;

  // R5: a frame never begins in a cycle after busy was high
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SEND && $past(state_q) != SEQ_SEND) |-> !$past(busy_i));

  // R2: a frame only begins after the delay phase
  a_r2_start_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SEND && $past(state_q) != SEQ_SEND) |-> $past(state_q) == SEQ_WAIT);

  // R1: bit counter stays inside the frame length
  a_r1_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SEND) |-> (bcnt_q <= LAST_BIT));

  // R8: an overlapping trigger always leaves a non-zero count
  a_r8_overrun_count: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && state_q != SEQ_IDLE) |=> (ovr_q != '0));
endmodule

// File: rtl/train_cmd_seq.sv
module train_cmd_seq #(
  parameter int ID_W  = 32,
  parameter int PID_W = 8,
  parameter int PAT_W = 16,
  parameter int DLY_W = 8,
  parameter int PER_W = 8,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel_i,
  input  logic             rx_trig_i,
  input  logic [ID_W-1:0]  rx_train_id_i,
  input  logic [PID_W-1:0] rx_pattern_id_i,
  input  logic             ext_trig_i,
  input  logic [ID_W-1:0]  ext_train_id_i,
  input  logic [PID_W-1:0] ext_pattern_id_i,
  input  logic             bunch_clk_i,
  input  logic [PER_W-1:0] sa_period_i,
  input  logic [PID_W-1:0] sa_pattern_id_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             busy_i,
  input  logic             veto_i,
  input  logic             lut_we_i,
  input  logic [PID_W-1:0] lut_addr_i,
  input  logic [PAT_W-1:0] lut_data_i,
  output logic             cmd_o,
  output logic             veto_o,
  output logic [PAT_W-1:0] bunch_pattern_o,
  output logic [OVR_W-1:0] overrun_cnt_o
);
  import tcs_pkg::*;

  logic             srst_n;
  logic             sa_en, sa_trig;
  logic [ID_W-1:0]  sa_id;
  logic             sel_trig;
  logic [ID_W-1:0]  sel_id;
  logic [PID_W-1:0] sel_pid;
  logic [PID_W-1:0] lut_raddr;
  logic [PAT_W-1:0] lut_rdata;
  logic             veto_q;

  assign sa_en = (src_e'(src_sel_i) == SRC_SA);

  tcs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  tcs_sa_gen #(.ID_W(ID_W), .PER_W(PER_W)) u_sa (
    .clk         (clk),
    .rst_n       (srst_n),
    .en_i        (sa_en),
    .bunch_clk_i (bunch_clk_i),
    .period_i    (sa_period_i),
    .trig_o      (sa_trig),
    .id_o        (sa_id)
  );

  tcs_src_sel #(.ID_W(ID_W), .PID_W(PID_W)) u_sel (
    .sel_i      (src_sel_i),
    .rx_trig_i  (rx_trig_i),
    .rx_id_i    (rx_train_id_i),
    .rx_pid_i   (rx_pattern_id_i),
    .ext_trig_i (ext_trig_i),
    .ext_id_i   (ext_train_id_i),
    .ext_pid_i  (ext_pattern_id_i),
    .sa_trig_i  (sa_trig),
    .sa_id_i    (sa_id),
    .sa_pid_i   (sa_pattern_id_i),
    .trig_o     (sel_trig),
    .id_o       (sel_id),
    .pid_o      (sel_pid)
  );

  tcs_pattern_lut #(.PID_W(PID_W), .PAT_W(PAT_W)) u_lut (
    .clk     (clk),
    .we_i    (lut_we_i),
    .waddr_i (lut_addr_i),
    .wdata_i (lut_data_i),
    .raddr_i (lut_raddr),
    .rdata_o (lut_rdata)
  );

  tcs_frame_seq #(
    .ID_W(ID_W), .PID_W(PID_W), .PAT_W(PAT_W), .DLY_W(DLY_W), .OVR_W(OVR_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .trig_i     (sel_trig),
    .id_i       (sel_id),
    .pid_i      (sel_pid),
    .delay_i    (delay_i),
    .busy_i     (busy_i),
    .lut_pat_i  (lut_rdata),
    .lut_addr_o (lut_raddr),
    .cmd_o      (cmd_o),
    .pattern_o  (bunch_pattern_o),
    .ovr_cnt_o  (overrun_cnt_o)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) veto_q <= 1'b0;
    else         veto_q <= veto_i;
  end

  assign veto_o = veto_q;
endmodule

// File: tb/train_cmd_seq_tb_top.sv
module train_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  src_sel;
  logic        rx_trig, ext_trig;
  logic [31:0] rx_id, ext_id;
  logic [7:0]  rx_pid, ext_pid;
  logic        bunch_clk = 1'b0;
  logic [7:0]  sa_period, sa_pid, delay;
  logic        busy, veto;
  logic        lut_we;
  logic [7:0]  lut_addr;
  logic [15:0] lut_data;
  logic        cmd;
  logic        veto_out;
  logic [15:0] pattern;
  logic [7:0]  ovr_cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int bdiv   = 0;

  // monitor state
  int          in_frame = 0;
  int          nbits    = 0;
  int          frames   = 0;
  int          start_cyc_w = 0;
  int          last_start  = 0;
  logic [45:0] fbuf, last_frame;
  logic        sa_mode = 1'b0;
  int          sa_n = 0;
  logic [31:0] sa_ids [16];
  int          sa_starts [16];
  int          trig_cyc = 0;

  train_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel),
    .rx_trig_i(rx_trig), .rx_train_id_i(rx_id), .rx_pattern_id_i(rx_pid),
    .ext_trig_i(ext_trig), .ext_train_id_i(ext_id), .ext_pattern_id_i(ext_pid),
    .bunch_clk_i(bunch_clk), .sa_period_i(sa_period), .sa_pattern_id_i(sa_pid),
    .delay_i(delay), .busy_i(busy), .veto_i(veto),
    .lut_we_i(lut_we), .lut_addr_i(lut_addr), .lut_data_i(lut_data),
    .cmd_o(cmd), .veto_o(veto_out), .bunch_pattern_o(pattern),
    .overrun_cnt_o(ovr_cnt)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // bunch clock: 20 fast cycles per period
  always @(negedge clk) begin
    bdiv = (bdiv == 19) ? 0 : bdiv + 1;
    bunch_clk = (bdiv < 10);
  end

  // frame monitor, samples away from the active edge
  always @(negedge clk) begin
    if (in_frame == 0 && cmd === 1'b1) begin
      in_frame = 1;
      nbits = 0;
      start_cyc_w = cyc;
    end
    if (in_frame == 1) begin
      fbuf = {fbuf[44:0], cmd};
      nbits++;
      if (nbits == 46) begin
        in_frame = 0;
        frames++;
        last_frame = fbuf;
        last_start = start_cyc_w;
        if (sa_mode && sa_n < 16) begin
          sa_ids[sa_n] = fbuf[42:11];
          sa_starts[sa_n] = start_cyc_w;
          sa_n++;
        end
      end
    end
  end

  function automatic logic [15:0] pat_of(input logic [7:0] p);
    return {p ^ 8'h3C, ~p};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig_cyc = cyc;
    rx_trig = 1'b1;
    ext_trig = 1'b1;
    @(negedge clk);
    rx_trig = 1'b0;
    ext_trig = 1'b0;
  endtask

  // vector: src[50:49] id[48:17] pid[16:9] dly[8:1] busy[0]
  localparam logic [50:0] VECS [6] = '{
    {2'd0, 32'h1234_5678, 8'hA5, 8'd0,  1'b0},
    {2'd1, 32'hDEAD_BEEF, 8'h3C, 8'd5,  1'b0},
    {2'd0, 32'h8000_0001, 8'hFF, 8'd17, 1'b0},
    {2'd0, 32'h0000_0000, 8'h00, 8'd3,  1'b1},
    {2'd1, 32'hFFFF_FFFF, 8'h81, 8'd1,  1'b0},
    {2'd1, 32'h0F0F_0F0F, 8'h5A, 8'd2,  1'b1}
  };

  initial begin
    rst_n = 1'b0; src_sel = 2'd3; rx_trig = 0; ext_trig = 0;
    rx_id = 0; ext_id = 0; rx_pid = 0; ext_pid = 0;
    sa_period = 8'd4; sa_pid = 8'h77; delay = 0; busy = 0; veto = 0;
    lut_we = 0; lut_addr = 0; lut_data = 0;
    cycles(5);
    rst_n = 1'b1;
    cycles(5);

    // R9: reset state
    chk("R9 cmd", cmd, 0);
    chk("R9 veto", veto_out, 0);
    chk("R9 overrun", ovr_cnt, 0);
    chk("R9 pattern", pattern, 0);

    // load pattern table (R6)
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_addr = 8'(a); lut_data = pat_of(8'(a));
    end
    @(negedge clk);
    lut_we = 1'b0;

    // R7: veto pass-through
    veto = 1'b1;
    @(negedge clk);
    chk("R7 veto high", veto_out, 1);
    veto = 1'b0;
    @(negedge clk);
    chk("R7 veto low", veto_out, 0);

    // vector table: R1 R2 R3 R5 R6
    for (int i = 0; i < 6; i++) begin
      logic [50:0] v;
      int f0;
      v = VECS[i];
      src_sel = v[50:49];
      delay   = v[8:1];
      busy    = v[0];
      if (v[50:49] == 2'd0) begin
        rx_id = v[48:17];  rx_pid = v[16:9];
        ext_id = v[48:17] ^ 32'h5555_5555; ext_pid = v[16:9] ^ 8'h0F;
      end else begin
        ext_id = v[48:17]; ext_pid = v[16:9];
        rx_id = v[48:17] ^ 32'h5555_5555; rx_pid = v[16:9] ^ 8'h0F;
      end
      f0 = frames;
      pulse_trig();
      cycles(int'(v[8:1]) + 60);
      if (v[0]) begin
        chk("R5 busy drops train", 64'(frames - f0), 0);
      end else begin
        chk("R3 one frame from selected source", 64'(frames - f0), 1);
        chk("R1 start marker", last_frame[45:43], 3'b110);
        chk("R3 train id", last_frame[42:11], v[48:17]);
        chk("R1 pattern id", last_frame[10:3], v[16:9]);
        chk("R1 stop marker", last_frame[2:0], 3'b011);
        chk("R2 latency", 64'(last_start - trig_cyc), 64'(int'(v[8:1]) + 2));
        chk("R6 pattern", pattern, pat_of(v[16:9]));
      end
      busy = 1'b0;
      chk("R1 idle low", cmd, 0);
    end

    // R8: overrun during a frame
    begin
      int f0;
      logic [7:0] o0;
      src_sel = 2'd0; delay = 8'd4;
      rx_id = 32'hCAFE_0001; rx_pid = 8'h11;
      f0 = frames; o0 = ovr_cnt;
      pulse_trig();
      cycles(10);
      rx_id = 32'hBAD0_0002;
      pulse_trig();
      cycles(3);
      pulse_trig();
      cycles(80);
      chk("R8 one frame only", 64'(frames - f0), 1);
      chk("R8 first train kept", last_frame[42:11], 32'hCAFE_0001);
      chk("R8 overrun count", ovr_cnt, o0 + 8'd2);
    end

    // R3: source none ignores both inputs
    begin
      int f0;
      src_sel = 2'd3;
      f0 = frames;
      pulse_trig();
      cycles(80);
      chk("R3 source none", 64'(frames - f0), 0);
    end

    // R4: standalone generator
    delay = 8'd2; sa_period = 8'd4; sa_pid = 8'h77;
    @(negedge clk);
    sa_mode = 1'b1;
    src_sel = 2'd2;
    cycles(500);
    src_sel = 2'd3;
    cycles(100);
    sa_mode = 1'b0;
    chk("R4 frame count", 64'(sa_n >= 4), 1);
    chk("R4 first id", sa_ids[0], 0);
    for (int k = 1; k < 4; k++) begin
      chk("R4 id step", sa_ids[k], sa_ids[k-1] + 32'd1);
      chk("R4 spacing", 64'(sa_starts[k] - sa_starts[k-1]), 80);
    end
    chk("R4 pattern id", last_frame[10:3], 8'h77);
    chk("R6 standalone pattern", pattern, pat_of(8'h77));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule